// File: doc/BRIEF.md
# Slot-to-Channel Map Sequencer

This block keeps a small dual-ported table that says which line channel owns each time slot of a 16-slot frame. A host writes and reads the table over a simple word-addressed port, where entry N lives at address 0x1400+N. The other side of the table belongs to a sequencer that sweeps the whole map twice per frame, so the channel order runs at the oversampled rate and not once per frame.

A pass begins on a frame-start pulse or on a half-frame pulse. Each pass is a receive sweep over slots 0 to 15 followed directly by a transmit sweep over the same slots. One entry comes out per cycle in which the step enable is high. The two consumers get their own valid strobes and share one slot-index bus and one channel-number bus. At the start of a pass the sequencer copies the channel fields of the table into a snapshot. A host write made while a pass runs therefore changes nothing in that pass and shows up in the next one. The table is not cleared at reset, so software must write all sixteen entries before it starts the first pass.

Top module: `slot_map_seq`

## Requirements
- R1: After reset `rx_valid`, `tx_valid` and `host_rvalid` are 0. While no pass has been started, `step_en` produces no strobe.
- R2: A write with `host_addr` = 0x1400+N (N in 0..15) stores `host_wdata` (6 bits) in entry N. A read of that address returns the entry on `host_rdata`, with `host_rvalid` = 1, in the cycle after the request. A read and a write to the same entry in the same cycle return the old value.
- R3: A write to an address outside 0x1400..0x140F changes no entry. A read of such an address gives `host_rvalid` = 0 in the following cycle.
- R4: A `frame_start` or `half_tick` pulse seen while the sequencer is idle starts a pass. The receive sweep then outputs slots 0,1,...,15 in order, one per cycle with `step_en` = 1. Each output appears in the cycle after that enabled cycle, with `rx_valid` = 1, `slot_idx` = slot and `slot_chan` = bits 3:0 of the entry.
- R5: After slot 15 of the receive sweep, the transmit sweep outputs slots 0..15 in the same way, with `tx_valid` = 1 and the same channel numbers.
- R6: `rx_valid` and `tx_valid` are never 1 together. Neither is 1 unless `step_en` was 1 in the previous cycle.
- R7: A start pulse that arrives while a pass is running is ignored. The sweep continues from its current slot without restarting.
- R8: A host write made during a pass, or in the same cycle as the start pulse, does not change any value presented in that pass. It is presented from the next pass on.
- R9: Bits 5:4 of an entry are stored and read back by the host, but they never appear on `slot_chan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read request |
| host_addr | input | 16 | Host word address |
| host_wdata | input | 6 | Host write data |
| host_rdata | output | 6 | Host read data |
| host_rvalid | output | 1 | Read data valid, one cycle after the read |
| frame_start | input | 1 | Frame-start pulse, starts a pass |
| half_tick | input | 1 | Half-frame pulse, starts a pass |
| step_en | input | 1 | Advance the sweep by one slot |
| rx_valid | output | 1 | Receive-path strobe |
| tx_valid | output | 1 | Transmit-path strobe |
| slot_idx | output | 4 | Slot index of the presented entry |
| slot_chan | output | 4 | Channel number of the presented entry |

## Verification
Two things can fall in the same cycle: a host write to the table, and a pass start or a sweep step that reads it. The bench provokes the collision by writing slot 0 in the very cycle of the start pulse. It also scatters random host writes and stray start pulses across random step-enable patterns. Every presented channel is compared against a bench copy of the table taken when the pass began. The written value must then appear only in the following pass.

// File: rtl/slot_map_pkg.sv
package slot_map_pkg;
  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_RX   = 2'd1,
    SW_TX   = 2'd2
  } sweep_st_e;
endpackage

// File: rtl/slot_table.sv
module slot_table #(
  parameter int SLOTS   = 16,
  parameter int ENTRY_W = 6,
  parameter int CHAN_W  = 4,
  parameter int ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1400
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_wr,
  input  logic                          host_rd,
  input  logic [ADDR_W-1:0]             host_addr,
  input  logic [ENTRY_W-1:0]            host_wdata,
  output logic [ENTRY_W-1:0]            host_rdata,
  output logic                          host_rvalid,
  output logic [SLOTS-1:0][CHAN_W-1:0]  chan_all
);
  localparam int IDX_W = $clog2(SLOTS);

  logic [ENTRY_W-1:0] mem_q [SLOTS];
  logic               hit;
  logic [IDX_W-1:0]   idx;
  logic [ENTRY_W-1:0] rdata_d, rdata_q;
  logic               rvalid_d, rvalid_q;

  assign hit = (host_addr[ADDR_W-1:IDX_W] == BASE_ADDR[ADDR_W-1:IDX_W]);
  assign idx = host_addr[IDX_W-1:0];

  // host port: table is data storage, left uninitialised
  always_ff @(posedge clk) begin
    if (host_wr && hit) mem_q[idx] <= host_wdata;
  end

  always_comb begin
    rvalid_d = host_rd && hit;
    rdata_d  = rdata_q;
    if (host_rd && hit) rdata_d = mem_q[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;

  // sequencer port: channel field of every entry
  for (genvar g = 0; g < SLOTS; g++) begin : g_chan
    assign chan_all[g] = mem_q[g][CHAN_W-1:0];
  end

  a_r2_rvalid_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_rd));
  a_r3_no_rvalid_off_map: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !hit) |=> !host_rvalid);
endmodule

// File: rtl/slot_snap.sv
module slot_snap #(
  parameter int SLOTS  = 16,
  parameter int CHAN_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [SLOTS-1:0][CHAN_W-1:0]  chan_in,
  output logic [SLOTS-1:0][CHAN_W-1:0]  snap_out
);
  logic [SLOTS-1:0][CHAN_W-1:0] snap_q;

  // per-slot capture, one clock enable for the whole copy
  for (genvar g = 0; g < SLOTS; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (load) snap_q[g] <= chan_in[g];
    end
  end

  assign snap_out = snap_q;

  a_r8_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(snap_q));
endmodule

// File: rtl/slot_sweep.sv
module slot_sweep
  import slot_map_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int CHAN_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_start,
  input  logic                          half_tick,
  input  logic                          step_en,
  input  logic [SLOTS-1:0][CHAN_W-1:0]  snap_in,
  output logic                          load,
  output logic                          rx_valid,
  output logic                          tx_valid,
  output logic [$clog2(SLOTS)-1:0]      slot_idx,
  output logic [CHAN_W-1:0]             slot_chan
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  sweep_st_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              rxv_d, txv_d, rxv_q, txv_q;
  logic [IDX_W-1:0]  slot_q;
  logic [CHAN_W-1:0] chan_q;
  logic              start;
  logic              out_en;

  assign start  = frame_start || half_tick;
  assign out_en = rxv_d || txv_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    load    = 1'b0;
    rxv_d   = 1'b0;
    txv_d   = 1'b0;
    unique case (state_q)
      SW_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = SW_RX;
          idx_d   = '0;
        end
      end
      SW_RX: begin
        if (step_en) begin
          rxv_d = 1'b1;
          if (idx_q == LAST) begin
            idx_d   = '0;
            state_d = SW_TX;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      SW_TX: begin
        if (step_en) begin
          txv_d = 1'b1;
          if (idx_q == LAST) begin
            idx_d   = '0;
            state_d = SW_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = SW_IDLE;
        idx_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      idx_q   <= '0;
      rxv_q   <= 1'b0;
      txv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rxv_q   <= rxv_d;
      txv_q   <= txv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      chan_q <= '0;
    end else if (out_en) begin
      slot_q <= idx_q;
      chan_q <= snap_in[idx_q];
    end
  end

  assign rx_valid  = rxv_q;
  assign tx_valid  = txv_q;
  assign slot_idx  = slot_q;
  assign slot_chan = chan_q;

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && tx_valid));
  a_r6_strobe_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || tx_valid) |-> $past(step_en));
  a_r4_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SW_IDLE && step_en && idx_q != LAST) |=> (idx_q == $past(idx_q) + 1'b1));
  a_r5_tx_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_RX && step_en && idx_q == LAST) |=> (state_q == SW_TX && idx_q == '0));
  a_r7_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SW_IDLE && !step_en) |=> ($stable(idx_q) && $stable(state_q)));
endmodule

// File: rtl/slot_map_seq.sv
module slot_map_seq #(
  parameter int SLOTS   = 16,
  parameter int ENTRY_W = 6,
  parameter int CHAN_W  = 4,
  parameter int ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1400
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_wr,
  input  logic                      host_rd,
  input  logic [ADDR_W-1:0]         host_addr,
  input  logic [ENTRY_W-1:0]        host_wdata,
  output logic [ENTRY_W-1:0]        host_rdata,
  output logic                      host_rvalid,
  input  logic                      frame_start,
  input  logic                      half_tick,
  input  logic                      step_en,
  output logic                      rx_valid,
  output logic                      tx_valid,
  output logic [$clog2(SLOTS)-1:0]  slot_idx,
  output logic [CHAN_W-1:0]         slot_chan
);
  logic [SLOTS-1:0][CHAN_W-1:0] chan_all;
  logic [SLOTS-1:0][CHAN_W-1:0] snap;
  logic                         load;

  slot_table #(
    .SLOTS(SLOTS), .ENTRY_W(ENTRY_W), .CHAN_W(CHAN_W),
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .chan_all(chan_all)
  );

  slot_snap #(.SLOTS(SLOTS), .CHAN_W(CHAN_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .load(load), .chan_in(chan_all), .snap_out(snap)
  );

  slot_sweep #(.SLOTS(SLOTS), .CHAN_W(CHAN_W)) u_sweep (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .half_tick(half_tick), .step_en(step_en),
    .snap_in(snap), .load(load),
    .rx_valid(rx_valid), .tx_valid(tx_valid),
    .slot_idx(slot_idx), .slot_chan(slot_chan)
  );
endmodule

// File: tb/slot_map_seq_test.sv
module slot_map_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, host_rd;
  logic [15:0] host_addr;
  logic [5:0]  host_wdata;
  logic [5:0]  host_rdata;
  logic        host_rvalid;
  logic        frame_start, half_tick, step_en;
  logic        rx_valid, tx_valid;
  logic [3:0]  slot_idx, slot_chan;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [5:0] model [16];
  logic [3:0] exp_snap [16];

  always #4 clk = ~clk;

  slot_map_seq uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .frame_start(frame_start), .half_tick(half_tick),
    .step_en(step_en), .rx_valid(rx_valid), .tx_valid(tx_valid),
    .slot_idx(slot_idx), .slot_chan(slot_chan)
  );

  function automatic logic [3:0] chan_of(input logic [5:0] e);
    return e[3:0];
  endfunction

  function automatic bit on_map(input logic [15:0] a);
    return (a >= 16'h1400) && (a <= 16'h140F);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in();
    host_wr = 0; host_rd = 0; host_addr = 16'h0; host_wdata = 6'h0;
    frame_start = 0; half_tick = 0; step_en = 0;
  endtask

  task automatic hwrite(input logic [15:0] a, input logic [5:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    tick();
    host_wr = 0;
    if (on_map(a)) model[a[3:0]] = d;
  endtask

  task automatic hread_chk(input logic [15:0] a, input string req);
    host_rd = 1; host_addr = a;
    tick();
    host_rd = 0;
    if (on_map(a)) begin
      chk(host_rvalid === 1'b1, req, host_rvalid, 1);
      chk(host_rdata === model[a[3:0]], req, host_rdata, model[a[3:0]]);
    end else begin
      chk(host_rvalid === 1'b0, req, host_rvalid, 0);
    end
  endtask

  // one pass: rx sweep then tx sweep; noise adds host writes and stray starts
  task automatic run_pass(input bit use_half, input bit collide, input bit noise);
    int k = 0;
    for (int i = 0; i < 16; i++) exp_snap[i] = chan_of(model[i]);
    if (use_half) half_tick = 1; else frame_start = 1;
    if (collide) begin
      host_wr = 1; host_addr = 16'h1400; host_wdata = ~model[0];
    end
    tick();
    if (collide) model[0] = host_wdata;
    idle_in();
    while (k < 32) begin
      bit st = ($urandom % 3) != 0;
      bit wr = noise && (($urandom % 4) == 0);
      logic [15:0] wa = 16'h1400 + 16'($urandom % 16);
      logic [5:0]  wd = 6'($urandom);
      step_en = st;
      host_wr = wr; host_addr = wa; host_wdata = wd;
      frame_start = noise && (($urandom % 5) == 0);
      half_tick   = noise && (($urandom % 5) == 0);
      tick();
      if (wr) model[wa[3:0]] = wd;
      if (st) begin
        if (k < 16) begin
          chk(rx_valid === 1 && tx_valid === 0, "R4", {rx_valid, tx_valid}, 2);
          chk(slot_idx === 4'(k), "R4", slot_idx, k);
          chk(slot_chan === exp_snap[k], noise ? "R8" : "R4", slot_chan, exp_snap[k]);
        end else begin
          chk(tx_valid === 1 && rx_valid === 0, "R5", {rx_valid, tx_valid}, 1);
          chk(slot_idx === 4'(k - 16), noise ? "R7" : "R5", slot_idx, k - 16);
          chk(slot_chan === exp_snap[k - 16], noise ? "R8" : "R5", slot_chan, exp_snap[k - 16]);
        end
        k++;
      end else begin
        chk(rx_valid === 0 && tx_valid === 0, "R6", {rx_valid, tx_valid}, 0);
      end
    end
    idle_in();
    step_en = 1;
    tick();
    chk(rx_valid === 0 && tx_valid === 0, "R5", {rx_valid, tx_valid}, 0);
    step_en = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1357));
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(rx_valid === 0 && tx_valid === 0, "R1", {rx_valid, tx_valid}, 0);
    chk(host_rvalid === 0, "R1", host_rvalid, 0);
    rst_n = 1;
    step_en = 1;
    repeat (4) begin
      tick();
      chk(rx_valid === 0 && tx_valid === 0, "R1", {rx_valid, tx_valid}, 0);
    end
    step_en = 0;

    // fill the table, then read it back
    for (int i = 0; i < 16; i++) hwrite(16'h1400 + 16'(i), 6'(i * 5 + 3));
    for (int i = 0; i < 16; i++) hread_chk(16'h1400 + 16'(i), "R2");

    // same-cycle read and write returns the old value
    host_wr = 1; host_rd = 1; host_addr = 16'h1407; host_wdata = 6'h2C;
    tick();
    host_wr = 0; host_rd = 0;
    chk(host_rvalid === 1 && host_rdata === model[7], "R2", host_rdata, model[7]);
    model[7] = 6'h2C;
    hread_chk(16'h1407, "R2");

    // off-map accesses
    hwrite(16'h1410, 6'h3F);
    hwrite(16'h13FF, 6'h3F);
    hwrite(16'h0400, 6'h3F);
    for (int i = 0; i < 16; i++) hread_chk(16'h1400 + 16'(i), "R3");
    hread_chk(16'h1410, "R3");
    hread_chk(16'h13FF, "R3");

    // upper bits stored but not presented
    hwrite(16'h1403, 6'h3A);
    hwrite(16'h140C, 6'h25);
    hread_chk(16'h1403, "R9");
    hread_chk(16'h140C, "R9");
    run_pass(1'b0, 1'b0, 1'b0);
    chk(exp_snap[3] === 4'hA, "R9", exp_snap[3], 4'hA);

    // write colliding with the start pulse, then seen one pass later
    run_pass(1'b1, 1'b1, 1'b0);
    run_pass(1'b0, 1'b0, 1'b0);
    chk(exp_snap[0] === chan_of(model[0]), "R8", exp_snap[0], chan_of(model[0]));

    // random passes with host traffic and stray start pulses
    for (int p = 0; p < 12; p++) run_pass(p[0], 1'b0, 1'b1);
    run_pass(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) hread_chk(16'h1400 + 16'(i), "R2");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule